// File: doc/BRIEF.md
# Host-to-CPU Doorbell Interrupt Register

This block holds a single doorbell flag between an external host port and a local processor. The host sets the flag by writing its control register. The processor acknowledges by clearing the flag. Both sides write the same bit with opposite meanings: for the host a 1 means "ring", and for the processor a 1 means "acknowledge". A host write of 1 that moves the flag from 0 to 1 sends one registered interrupt pulse to the processor. A host write of 1 while the flag is already set is locked out, so it neither re-fires the pulse nor changes the flag.

The flag is visible to both sides through separate read outputs. The host can therefore poll for a cleared flag before it rings again. A synchronous active-low reset clears the flag at once and drops any pending interrupt.

Top module: `doorbell_reg`

## Requirements
- R1: A host write reaches the doorbell only when both control-select lines are low (`host_sel` = 2'b00). A host write with any other select code leaves the flag unchanged.
- R2: A host write with data 1, made while the flag is 0, sets the flag. The new value appears on the read outputs in the cycle after the write edge.
- R3: `cpu_irq` is driven from a register. It goes high for exactly one clock cycle, in the same cycle the flag becomes 1, and it never rises while the flag stays 0.
- R4: While the flag is 1, a host write of data 1 produces no pulse and the flag stays at 1.
- R5: A processor write with data 1 forces the flag to 0 on the next edge.
- R6: A write with data 0 from either side changes neither the flag nor `cpu_irq`.
- R7: When a host set and a processor clear arrive in the same cycle, the outcome depends on the flag. If the flag is 1, the clear wins: the flag goes to 0 and no pulse is sent. If the flag is 0, the set wins: the flag goes to 1 and one pulse is sent.
- R8: A synchronous active-low reset clears the flag and `cpu_irq`, even when a host set is present in the same cycle. `cpu_irq` is low throughout reset and during the first cycle after reset is released.
- R9: `host_rd_flag` and `cpu_rd_flag` both always show the current flag value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_sel | input | 2 | Host control-select lines; 2'b00 addresses the control register |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 1 | Host write data for the doorbell bit |
| cpu_wr | input | 1 | Processor write strobe |
| cpu_wdata | input | 1 | Processor write data for the doorbell bit |
| cpu_irq | output | 1 | One-cycle interrupt pulse to the processor |
| host_rd_flag | output | 1 | Flag value as seen by the host |
| cpu_rd_flag | output | 1 | Flag value as seen by the processor |

## Verification
The bench builds the block with its default two-bit select width and a control code of zero. With these values every select code can be driven, and the full cross of select, both strobes and both data bits (64 input patterns) is swept from each flag state. The next flag value and the pulse are computed arithmetically from the set and clear rules. This sweep covers the same-cycle arbitration in both directions, the lockout, and the ignored select codes. Separate reset sequences check that a pending flag is cancelled and that a pulse cannot appear during reset or in the cycle after it.

// File: rtl/doorbell_pkg.sv
package doorbell_pkg;

    // Registered state of the doorbell block
    typedef struct packed {
        logic flag;   // doorbell bit
        logic irq;    // one-cycle interrupt pulse
    } db_state_t;

    // Write-side requests after decoding
    typedef struct packed {
        logic set;    // qualified host ring
        logic clr;    // qualified processor acknowledge
    } db_req_t;

    localparam db_state_t DB_RESET = '{flag: 1'b0, irq: 1'b0};

endpackage

// File: rtl/doorbell_host_dec.sv
module doorbell_host_dec #(
    parameter int              SEL_W     = 2,
    parameter logic [SEL_W-1:0] CTRL_CODE = '0
) (
    input  logic [SEL_W-1:0] sel,
    input  logic             wr,
    input  logic             wdata,
    output logic             set_req
);
    logic hit;

    always_comb begin
        hit     = (sel == CTRL_CODE);
        set_req = wr && hit && wdata;
    end
endmodule

// File: rtl/doorbell_cpu_dec.sv
module doorbell_cpu_dec (
    input  logic wr,
    input  logic wdata,
    output logic clr_req
);
    always_comb begin
        clr_req = wr && wdata;
    end
endmodule

// File: rtl/doorbell_core.sv
module doorbell_core
    import doorbell_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  db_req_t req,
    output logic    flag,
    output logic    irq
);
    db_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.flag) begin
            st_d.flag = !req.clr;
            st_d.irq  = 1'b0;
        end else begin
            st_d.flag = req.set;
            st_d.irq  = req.set;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= DB_RESET;
        else        st_q <= st_d;
    end

    assign flag = st_q.flag;
    assign irq  = st_q.irq;

    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq); // R3
    AST_IRQ_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> irq); // R3
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag); // R3
    AST_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !req.clr) |=> (flag && !irq)); // R4
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && req.clr) |=> (!flag && !irq)); // R5
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag && !req.set) |=> (!flag && !irq)); // R6
    AST_SET_WINS_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag && req.set) |=> (flag && irq)); // R7
    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (!flag && !irq)); // R8
endmodule

// File: rtl/doorbell_reg.sv
module doorbell_reg
    import doorbell_pkg::*;
#(
    parameter int               SEL_W     = 2,
    parameter logic [SEL_W-1:0] CTRL_CODE = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] host_sel,
    input  logic             host_wr,
    input  logic             host_wdata,
    input  logic             cpu_wr,
    input  logic             cpu_wdata,
    output logic             cpu_irq,
    output logic             host_rd_flag,
    output logic             cpu_rd_flag
);
    db_req_t req;
    logic    flag;
    logic    set_req;
    logic    clr_req;

    doorbell_host_dec #(.SEL_W(SEL_W), .CTRL_CODE(CTRL_CODE)) host_dec_i (
        .sel     (host_sel),
        .wr      (host_wr),
        .wdata   (host_wdata),
        .set_req (set_req)
    );

    doorbell_cpu_dec cpu_dec_i (
        .wr      (cpu_wr),
        .wdata   (cpu_wdata),
        .clr_req (clr_req)
    );

    always_comb begin
        req.set = set_req;
        req.clr = clr_req;
    end

    doorbell_core core_i (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (req),
        .flag  (flag),
        .irq   (cpu_irq)
    );

    assign host_rd_flag = flag;
    assign cpu_rd_flag  = flag;

    AST_OTHER_SEL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (host_sel != CTRL_CODE && !(cpu_wr && cpu_wdata)) |=> $stable(host_rd_flag)); // R1
    AST_READS_AGREE: assert property (@(posedge clk)
        host_rd_flag == cpu_rd_flag); // R9
endmodule

// File: tb/doorbell_reg_tb.sv
`timescale 1ns/1ps
module doorbell_reg_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] host_sel = 2'b11;
    logic       host_wr = 1'b0;
    logic       host_wdata = 1'b0;
    logic       cpu_wr = 1'b0;
    logic       cpu_wdata = 1'b0;
    logic       cpu_irq;
    logic       host_rd_flag;
    logic       cpu_rd_flag;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    doorbell_reg dut_i (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
        .host_wdata(host_wdata), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
        .cpu_irq(cpu_irq), .host_rd_flag(host_rd_flag), .cpu_rd_flag(cpu_rd_flag)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic check_flag(input string req, input logic exp);
        check(req, "host_rd_flag", host_rd_flag, exp);
        check("R9", "cpu_rd_flag", cpu_rd_flag, exp);
    endtask

    // drive one cycle of inputs, sample after the edge, return to idle
    task automatic step(input logic [1:0] s, input logic hw, input logic hd,
                        input logic cw, input logic cd);
        @(negedge clk);
        host_sel = s; host_wr = hw; host_wdata = hd; cpu_wr = cw; cpu_wdata = cd;
        @(negedge clk);
        host_sel = 2'b11; host_wr = 1'b0; host_wdata = 1'b0; cpu_wr = 1'b0; cpu_wdata = 1'b0;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        // R8: reset state
        check("R8", "cpu_irq in reset", cpu_irq, 1'b0);
        check_flag("R8", 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8", "cpu_irq after release", cpu_irq, 1'b0);

        // Sweep: each starting flag state crossed with all 64 input patterns
        for (int init = 0; init < 2; init++) begin
            for (int pat = 0; pat < 64; pat++) begin
                logic [1:0] s;
                logic hw, hd, cw, cd, setq, clrq, exp_flag, exp_irq;
                s  = pat[1:0];
                hw = pat[2]; hd = pat[3]; cw = pat[4]; cd = pat[5];
                // bring flag to starting state
                if (init == 0) step(2'b11, 1'b0, 1'b0, 1'b1, 1'b1);
                else           step(2'b00, 1'b1, 1'b1, 1'b0, 1'b0);
                idle();
                check_flag("R9", init[0]);
                check("R3", "cpu_irq idle before vector", cpu_irq, 1'b0);
                step(s, hw, hd, cw, cd);
                setq = hw && (s == 2'b00) && hd;
                clrq = cw && cd;
                exp_flag = init[0] ? !clrq : setq;
                exp_irq  = !init[0] && setq;
                if (s != 2'b00 && !clrq)
                    check_flag("R1", exp_flag);
                else if (setq && clrq)
                    check_flag("R7", exp_flag);
                else if (init == 1 && setq)
                    check_flag("R4", exp_flag);
                else if (clrq)
                    check_flag("R5", exp_flag);
                else if (setq)
                    check_flag("R2", exp_flag);
                else
                    check_flag("R6", exp_flag);
                check((setq && clrq) ? "R7" : "R3", "cpu_irq", cpu_irq, exp_irq);
                idle();
                check("R3", "cpu_irq second cycle", cpu_irq, 1'b0);
            end
        end

        // R8: reset cancels a pending flag, even with a host ring in the same cycle
        step(2'b00, 1'b1, 1'b1, 1'b0, 1'b0);
        check_flag("R2", 1'b1);
        @(negedge clk);
        rst_n = 1'b0; host_sel = 2'b00; host_wr = 1'b1; host_wdata = 1'b1;
        @(negedge clk);
        check_flag("R8", 1'b0);
        check("R8", "cpu_irq during reset with ring", cpu_irq, 1'b0);
        @(negedge clk);
        check("R8", "cpu_irq held in reset", cpu_irq, 1'b0);
        host_wr = 1'b0; host_wdata = 1'b0; host_sel = 2'b11;
        rst_n = 1'b1;
        @(negedge clk);
        check("R8", "cpu_irq cycle after release", cpu_irq, 1'b0);
        check_flag("R8", 1'b0);
        // first ring after reset works normally
        step(2'b00, 1'b1, 1'b1, 1'b0, 1'b0);
        check("R3", "cpu_irq ring after reset", cpu_irq, 1'b1);
        check_flag("R2", 1'b1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule